// File: doc/BRIEF.md
# Event Blocking State Tracker

This block keeps the short-lived conditions that hold back event delivery in a simple processor core, and the core's coarse activity state. Single-cycle strobes from the rest of the core report what just happened: an instruction retired, an interrupt-enable instruction ran (with the current interrupt-enable flag), the stack segment was loaded, a non-maskable or system-management interrupt was delivered, an interrupt return completed, system-management mode was entered or left, a halt, a shutdown, or a startup IPI arrived. From this the block drives four permission outputs that the delivery logic consults before it takes an event.

Each blocking condition has its own lifetime. The two instruction-shadow conditions last for exactly one following instruction. The SMI condition lasts for the whole stay in system-management mode. The NMI condition lasts until the next interrupt return. A mode input turns the NMI condition into a virtual flag that no longer gates real NMIs. On an exit strobe the block captures a 32-bit packed status word. On a load strobe it takes a status word and an activity value back, and it rejects the load with a one-cycle fail pulse if any reserved bit is set.

The activity state is a four-state machine. Its states are RUN (0), HALTED (1), DOWN (2) and WAIT_SIPI (3). Its transitions are HLT_TAKEN (RUN to HALTED on a halt), SHUTDOWN (any state to DOWN), SIPI_WAKE (WAIT_SIPI to RUN on a startup IPI) and LOAD (any state to the loaded value on an accepted load).

Top module: `evt_block_tracker`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, all four blocking bits clear, the activity state becomes RUN (0), `saved_o` becomes 0 and `load_fail_o` becomes 0.
- R2: The interrupt-shadow bit (status bit 0) sets on `sti_i` only when `if_flag_i` is 0. `sti_i` with `if_flag_i` equal to 1 leaves that bit unchanged.
- R3: The two one-instruction bits (status bits 0 and 1) do not clear on a `retire_i` strobe in the cycle that sets them. They clear on the first `retire_i` in a later cycle.
- R4: `ss_load_i` sets the stack-load bit (status bit 1). While that bit is set, both `int_ok_o` and `dbg_ok_o` are low.
- R5: The SMI bit (status bit 2) sets on `smm_enter_i` and clears on `smm_exit_i`. `smi_ok_o` is low exactly while the bit is set.
- R6: The NMI bit (status bit 3) sets on `nmi_dlv_i` or `smi_dlv_i` and clears on `iret_i`. A delivery in the same cycle as `iret_i` wins.
- R7: With `vnmi_mode_i` equal to 1, `nmi_ok_o` is high whatever status bit 3 holds, and bit 3 is still set and cleared as in R6. With `vnmi_mode_i` equal to 0, `nmi_ok_o` is the inverse of bit 3.
- R8: An `exit_i` strobe makes `saved_o` hold, from the next cycle, the blocking bits in positions 3:0 as they were before that edge, `enclave_i` in bit 4, and zeros in bits 31:5.
- R9: A `load_i` whose word has bits 31:5 all zero copies bits 3:0 into the blocking bits and `load_act_i` into the activity state. Bit 4 of the word is ignored. This load overrides every other strobe in the same cycle.
- R10: A `load_i` whose word has any of bits 31:5 set raises `load_fail_o` for exactly the next cycle and changes neither the blocking bits nor the activity state. Other strobes in that cycle act as usual.
- R11: Activity transitions: `hlt_i` in RUN goes to HALTED (1); `shutdown_i` in any state goes to DOWN (2); `sipi_i` in WAIT_SIPI (3) goes to RUN (0). `hlt_i` outside RUN and `sipi_i` outside WAIT_SIPI are ignored. Shutdown has priority over the other two.
- R12: `int_ok_o` is high only when `if_flag_i` is 1 and status bits 0 and 1 are both clear. It responds to `if_flag_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire_i | input | 1 | Instruction retired strobe |
| sti_i | input | 1 | Interrupt-enable instruction executed |
| if_flag_i | input | 1 | Current interrupt-enable flag |
| ss_load_i | input | 1 | Stack segment loaded by move or pop |
| nmi_dlv_i | input | 1 | NMI delivered |
| smi_dlv_i | input | 1 | SMI delivered |
| iret_i | input | 1 | Interrupt return completed |
| smm_enter_i | input | 1 | System-management mode entered |
| smm_exit_i | input | 1 | System-management mode left |
| hlt_i | input | 1 | Halt executed |
| shutdown_i | input | 1 | Shutdown event (triple fault or other serious error) |
| sipi_i | input | 1 | Startup IPI received |
| vnmi_mode_i | input | 1 | Virtual-NMI mode |
| enclave_i | input | 1 | Core is currently in enclave mode |
| exit_i | input | 1 | Exit strobe; captures the status word |
| load_i | input | 1 | Entry strobe; loads status word and activity |
| load_word_i | input | 32 | Status word offered on entry |
| load_act_i | input | 2 | Activity value offered on entry |
| int_ok_o | output | 1 | Maskable interrupt may be delivered |
| nmi_ok_o | output | 1 | NMI may be delivered |
| smi_ok_o | output | 1 | SMI may be delivered |
| dbg_ok_o | output | 1 | Debug exceptions may be delivered |
| saved_o | output | 32 | Status word captured at the last exit |
| act_o | output | 2 | Activity state |
| load_fail_o | output | 1 | Entry rejected (one-cycle pulse) |

## Verification
The bench builds the tracker with its default 32-bit status word. That puts 27 reserved bits in reach of the load check: the random phase sets single high reserved bits and whole reserved patterns, so the rejection is exercised at both ends of the field. Because the word is 32 bits wide, the exit capture can be compared bit for bit against a behavioural model every cycle, including the enclave flag in bit 4. The same capture exposes status bit 3 in virtual-NMI mode, where no permission output shows it.

// File: rtl/ebt_pkg.sv
`timescale 1ns/1ps
package ebt_pkg;
    typedef enum logic [1:0] {
        ACT_RUN       = 2'd0,
        ACT_HALTED    = 2'd1,
        ACT_DOWN      = 2'd2,
        ACT_WAIT_SIPI = 2'd3
    } act_e;

    localparam int BLK_N    = 4;
    localparam int SHOT_N   = 2;
    localparam int IDX_STI  = 0;
    localparam int IDX_SS   = 1;
    localparam int IDX_SMI  = 2;
    localparam int IDX_NMI  = 3;
    localparam int IDX_ENCL = 4;
endpackage

// File: rtl/ebt_entry_check.sv
`timescale 1ns/1ps
module ebt_entry_check #(
    parameter int WORD_W = 32,
    parameter int USED_W = 5
) (
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              load_ok_o,
    output logic              load_bad_o
);
    localparam int RSV_W = WORD_W - USED_W;

    logic rsv_dirty;

    always_comb begin
        rsv_dirty  = |word_i[WORD_W-1:USED_W];
        load_ok_o  = load_i & ~rsv_dirty;
        load_bad_o = load_i & rsv_dirty;
    end

    initial begin
        if (RSV_W < 1) $error("reserved field must be at least one bit wide");
    end
endmodule

// File: rtl/ebt_block_bits.sv
`timescale 1ns/1ps
module ebt_block_bits
    import ebt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             retire_i,
    input  logic [SHOT_N-1:0] shot_set_i,
    input  logic             smm_enter_i,
    input  logic             smm_exit_i,
    input  logic             nmi_set_i,
    input  logic             iret_i,
    input  logic             load_ok_i,
    input  logic [BLK_N-1:0] load_bits_i,
    output logic [BLK_N-1:0] bits_o
);
    logic [BLK_N-1:0] bits_q;

    genvar g;
    generate
        for (g = 0; g < SHOT_N; g++) begin : g_shot
            always_ff @(posedge clk) begin
                if (rst)                 bits_q[g] <= 1'b0;
                else if (load_ok_i)      bits_q[g] <= load_bits_i[g];
                else if (shot_set_i[g])  bits_q[g] <= 1'b1;
                else if (retire_i)       bits_q[g] <= 1'b0;
            end

            p_shot_hold_r3: assert property (@(posedge clk) disable iff (rst)
                shot_set_i[g] && !load_ok_i |=> bits_q[g]);
            p_shot_clear_r3: assert property (@(posedge clk) disable iff (rst)
                bits_q[g] && retire_i && !shot_set_i[g] && !load_ok_i |=> !bits_q[g]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)              bits_q[IDX_SMI] <= 1'b0;
        else if (load_ok_i)   bits_q[IDX_SMI] <= load_bits_i[IDX_SMI];
        else if (smm_enter_i) bits_q[IDX_SMI] <= 1'b1;
        else if (smm_exit_i)  bits_q[IDX_SMI] <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)             bits_q[IDX_NMI] <= 1'b0;
        else if (load_ok_i)  bits_q[IDX_NMI] <= load_bits_i[IDX_NMI];
        else if (nmi_set_i)  bits_q[IDX_NMI] <= 1'b1;
        else if (iret_i)     bits_q[IDX_NMI] <= 1'b0;
    end

    assign bits_o = bits_q;

    p_smm_enter_r5: assert property (@(posedge clk) disable iff (rst)
        smm_enter_i && !load_ok_i |=> bits_q[IDX_SMI]);
    p_nmi_iret_r6: assert property (@(posedge clk) disable iff (rst)
        iret_i && !nmi_set_i && !load_ok_i |=> !bits_q[IDX_NMI]);
    p_nmi_wins_r6: assert property (@(posedge clk) disable iff (rst)
        nmi_set_i && !load_ok_i |=> bits_q[IDX_NMI]);
endmodule

// File: rtl/ebt_activity_fsm.sv
`timescale 1ns/1ps
module ebt_activity_fsm
    import ebt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hlt_i,
    input  logic       shutdown_i,
    input  logic       sipi_i,
    input  logic       load_ok_i,
    input  logic [1:0] load_act_i,
    output act_e       state_o
);
    act_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ACT_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load_ok_i) begin
            state_d = act_e'(load_act_i);
        end else if (shutdown_i) begin
            state_d = ACT_DOWN;
        end else begin
            unique case (state_q)
                ACT_RUN:       if (hlt_i)  state_d = ACT_HALTED;
                ACT_HALTED:    state_d = ACT_HALTED;
                ACT_DOWN:      state_d = ACT_DOWN;
                ACT_WAIT_SIPI: if (sipi_i) state_d = ACT_RUN;
                default:       state_d = ACT_RUN;
            endcase
        end
    end

    assign state_o = state_q;

    p_hlt_taken_r11: assert property (@(posedge clk) disable iff (rst)
        state_q == ACT_RUN && hlt_i && !shutdown_i && !load_ok_i |=> state_q == ACT_HALTED);
    p_shutdown_r11: assert property (@(posedge clk) disable iff (rst)
        shutdown_i && !load_ok_i |=> state_q == ACT_DOWN);
    p_sipi_stray_r11: assert property (@(posedge clk) disable iff (rst)
        state_q != ACT_WAIT_SIPI && state_q != ACT_RUN && !shutdown_i && !load_ok_i
        |=> $stable(state_q));
    p_load_act_r9: assert property (@(posedge clk) disable iff (rst)
        load_ok_i |=> state_q == act_e'($past(load_act_i)));
endmodule

// File: rtl/evt_block_tracker.sv
`timescale 1ns/1ps
module evt_block_tracker
    import ebt_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              retire_i,
    input  logic              sti_i,
    input  logic              if_flag_i,
    input  logic              ss_load_i,
    input  logic              nmi_dlv_i,
    input  logic              smi_dlv_i,
    input  logic              iret_i,
    input  logic              smm_enter_i,
    input  logic              smm_exit_i,
    input  logic              hlt_i,
    input  logic              shutdown_i,
    input  logic              sipi_i,
    input  logic              vnmi_mode_i,
    input  logic              enclave_i,
    input  logic              exit_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic [1:0]        load_act_i,
    output logic              int_ok_o,
    output logic              nmi_ok_o,
    output logic              smi_ok_o,
    output logic              dbg_ok_o,
    output logic [WORD_W-1:0] saved_o,
    output logic [1:0]        act_o,
    output logic              load_fail_o
);
    localparam int USED_W = BLK_N + 1;
    localparam int RSV_W  = WORD_W - USED_W;

    logic              load_ok, load_bad;
    logic [SHOT_N-1:0] shot_set;
    logic [BLK_N-1:0]  blk;
    act_e              act;
    logic [WORD_W-1:0] saved_q;
    logic              fail_q;

    ebt_entry_check #(.WORD_W(WORD_W), .USED_W(USED_W)) u_check (
        .load_i    (load_i),
        .word_i    (load_word_i),
        .load_ok_o (load_ok),
        .load_bad_o(load_bad)
    );

    always_comb begin
        shot_set[IDX_STI] = sti_i & ~if_flag_i;
        shot_set[IDX_SS]  = ss_load_i;
    end

    ebt_block_bits u_bits (
        .clk        (clk),
        .rst        (rst),
        .retire_i   (retire_i),
        .shot_set_i (shot_set),
        .smm_enter_i(smm_enter_i),
        .smm_exit_i (smm_exit_i),
        .nmi_set_i  (nmi_dlv_i | smi_dlv_i),
        .iret_i     (iret_i),
        .load_ok_i  (load_ok),
        .load_bits_i(load_word_i[BLK_N-1:0]),
        .bits_o     (blk)
    );

    ebt_activity_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hlt_i     (hlt_i),
        .shutdown_i(shutdown_i),
        .sipi_i    (sipi_i),
        .load_ok_i (load_ok),
        .load_act_i(load_act_i),
        .state_o   (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_q <= '0;
            fail_q  <= 1'b0;
        end else begin
            fail_q <= load_bad;
            if (exit_i) saved_q <= {{RSV_W{1'b0}}, enclave_i, blk};
        end
    end

    always_comb begin
        int_ok_o    = if_flag_i & ~blk[IDX_STI] & ~blk[IDX_SS];
        nmi_ok_o    = vnmi_mode_i | ~blk[IDX_NMI];
        smi_ok_o    = ~blk[IDX_SMI];
        dbg_ok_o    = ~blk[IDX_SS];
        saved_o     = saved_q;
        act_o       = act;
        load_fail_o = fail_q;
    end

    p_fail_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        load_i && |load_word_i[WORD_W-1:USED_W] |=> load_fail_o);
    p_fail_clean_r10: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> !load_fail_o);
    p_saved_encl_r8: assert property (@(posedge clk) disable iff (rst)
        exit_i |=> saved_o[IDX_ENCL] == $past(enclave_i));
    p_ss_gates_r4: assert property (@(posedge clk) disable iff (rst)
        ss_load_i && !load_i |=> !int_ok_o && !dbg_ok_o);
    p_sti_gate_r2: assert property (@(posedge clk) disable iff (rst)
        sti_i && !if_flag_i && !load_i |=> !int_ok_o);
endmodule

// File: tb/evt_block_tracker_tb_top.sv
`timescale 1ns/1ps
module evt_block_tracker_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic retire_i, sti_i, if_flag_i, ss_load_i, nmi_dlv_i, smi_dlv_i, iret_i;
    logic smm_enter_i, smm_exit_i, hlt_i, shutdown_i, sipi_i, vnmi_mode_i, enclave_i;
    logic exit_i, load_i;
    logic [31:0] load_word_i;
    logic [1:0]  load_act_i;
    logic int_ok_o, nmi_ok_o, smi_ok_o, dbg_ok_o, load_fail_o;
    logic [31:0] saved_o;
    logic [1:0]  act_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit compare_on = 0;
    bit done = 0;

    // behavioural reference
    int mb0, mb1, mb2, mb3, mact, mfail;
    logic [31:0] msaved;

    always #10 clk = ~clk;

    evt_block_tracker dut_i (
        .clk(clk), .rst(rst), .retire_i(retire_i), .sti_i(sti_i), .if_flag_i(if_flag_i),
        .ss_load_i(ss_load_i), .nmi_dlv_i(nmi_dlv_i), .smi_dlv_i(smi_dlv_i), .iret_i(iret_i),
        .smm_enter_i(smm_enter_i), .smm_exit_i(smm_exit_i), .hlt_i(hlt_i),
        .shutdown_i(shutdown_i), .sipi_i(sipi_i), .vnmi_mode_i(vnmi_mode_i),
        .enclave_i(enclave_i), .exit_i(exit_i), .load_i(load_i), .load_word_i(load_word_i),
        .load_act_i(load_act_i), .int_ok_o(int_ok_o), .nmi_ok_o(nmi_ok_o),
        .smi_ok_o(smi_ok_o), .dbg_ok_o(dbg_ok_o), .saved_o(saved_o), .act_o(act_o),
        .load_fail_o(load_fail_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    always @(posedge clk) begin
        int n0, n1, n2, n3, nact;
        bit ok;
        if (rst) begin
            mb0 = 0; mb1 = 0; mb2 = 0; mb3 = 0; mact = 0; mfail = 0; msaved = 0;
        end else begin
            ok = load_i && (load_word_i[31:5] == 27'd0);
            if (exit_i) msaved = {27'd0, enclave_i, mb3[0], mb2[0], mb1[0], mb0[0]};
            mfail = (load_i && !ok) ? 1 : 0;
            if (ok) begin
                n0 = load_word_i[0]; n1 = load_word_i[1];
                n2 = load_word_i[2]; n3 = load_word_i[3];
                nact = load_act_i;
            end else begin
                n0 = (sti_i && !if_flag_i) ? 1 : (retire_i ? 0 : mb0);
                n1 = ss_load_i ? 1 : (retire_i ? 0 : mb1);
                n2 = smm_enter_i ? 1 : (smm_exit_i ? 0 : mb2);
                n3 = (nmi_dlv_i || smi_dlv_i) ? 1 : (iret_i ? 0 : mb3);
                if (shutdown_i) nact = 2;
                else if (mact == 0 && hlt_i) nact = 1;
                else if (mact == 3 && sipi_i) nact = 0;
                else nact = mact;
            end
            mb0 = n0; mb1 = n1; mb2 = n2; mb3 = n3; mact = nact;
        end
    end

    always @(negedge clk) begin
        #5;
        if (compare_on) begin
            chk("R12 int_ok", 32'(int_ok_o), 32'(if_flag_i && mb0 == 0 && mb1 == 0));
            chk("R7 nmi_ok",  32'(nmi_ok_o), 32'(vnmi_mode_i || mb3 == 0));
            chk("R5 smi_ok",  32'(smi_ok_o), 32'(mb2 == 0));
            chk("R4 dbg_ok",  32'(dbg_ok_o), 32'(mb1 == 0));
            chk("R8 saved",   saved_o, msaved);
            chk("R11 act",    32'(act_o), 32'(mact));
            chk("R10 fail",   32'(load_fail_o), 32'(mfail));
        end
    end

    task automatic clear_strobes();
        retire_i = 0; sti_i = 0; ss_load_i = 0; nmi_dlv_i = 0; smi_dlv_i = 0;
        iret_i = 0; smm_enter_i = 0; smm_exit_i = 0; hlt_i = 0; shutdown_i = 0;
        sipi_i = 0; exit_i = 0; load_i = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic do_exit();
        exit_i = 1;
        tick();
    endtask

    initial begin
        rst = 1; clear_strobes();
        if_flag_i = 1; vnmi_mode_i = 0; enclave_i = 0;
        load_word_i = 0; load_act_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        compare_on = 1;
        #5;
        // R1 reset state
        chk("R1 act", 32'(act_o), 0);
        chk("R1 saved", saved_o, 0);
        chk("R1 fail", 32'(load_fail_o), 0);
        chk("R1 smi_ok", 32'(smi_ok_o), 1);
        @(negedge clk);

        // R2: STI with IF=1 has no effect, with IF=0 sets shadow
        sti_i = 1; if_flag_i = 1; tick();
        do_exit(); #5; chk("R2 no set with IF=1", saved_o, 32'h0);
        @(negedge clk);
        if_flag_i = 0; sti_i = 1; retire_i = 1; tick();
        do_exit(); #5; chk("R3 survives same-cycle retire", saved_o, 32'h1);
        @(negedge clk);
        retire_i = 1; tick();
        do_exit(); #5; chk("R3 cleared on later retire", saved_o, 32'h0);
        @(negedge clk);

        // R4 stack load
        if_flag_i = 1; ss_load_i = 1; tick(); #5;
        chk("R4 int blocked", 32'(int_ok_o), 0);
        chk("R4 dbg blocked", 32'(dbg_ok_o), 0);
        @(negedge clk); retire_i = 1; tick();

        // R5 SMM
        smm_enter_i = 1; tick(); #5; chk("R5 smi blocked", 32'(smi_ok_o), 0);
        @(negedge clk); smm_exit_i = 1; tick(); #5; chk("R5 smi open", 32'(smi_ok_o), 1);
        @(negedge clk);

        // R6 NMI and IRET, delivery wins
        nmi_dlv_i = 1; iret_i = 1; tick(); #5; chk("R6 delivery wins", 32'(nmi_ok_o), 0);
        @(negedge clk); iret_i = 1; tick(); #5; chk("R6 iret clears", 32'(nmi_ok_o), 1);
        @(negedge clk);

        // R7 virtual NMI mode
        vnmi_mode_i = 1; smi_dlv_i = 1; tick(); #5; chk("R7 nmi_ok in vnmi", 32'(nmi_ok_o), 1);
        @(negedge clk); enclave_i = 1; do_exit(); #5;
        chk("R8 saved word", saved_o, 32'h18);
        @(negedge clk); enclave_i = 0; vnmi_mode_i = 0; iret_i = 1; tick();

        // R11 activity
        sipi_i = 1; tick(); #5; chk("R11 stray sipi", 32'(act_o), 0);
        @(negedge clk); hlt_i = 1; tick(); #5; chk("R11 halt", 32'(act_o), 1);
        @(negedge clk); hlt_i = 1; sipi_i = 1; tick(); #5; chk("R11 halted stays", 32'(act_o), 1);
        @(negedge clk); shutdown_i = 1; tick(); #5; chk("R11 shutdown", 32'(act_o), 2);
        @(negedge clk);

        // R9 valid load overrides same-cycle strobes
        load_i = 1; load_word_i = 32'h0000_001A; load_act_i = 2'd3;
        shutdown_i = 1; smm_enter_i = 1; tick(); #5;
        chk("R9 act loaded", 32'(act_o), 3);
        chk("R9 smi bit from word", 32'(smi_ok_o), 1);
        @(negedge clk); do_exit(); #5; chk("R9 bits loaded, bit4 ignored", saved_o, 32'hA);
        @(negedge clk); sipi_i = 1; tick(); #5; chk("R11 sipi wake", 32'(act_o), 0);
        @(negedge clk);

        // R10 rejected load
        load_i = 1; load_word_i = 32'h8000_0000; load_act_i = 2'd1; tick(); #5;
        chk("R10 fail pulse", 32'(load_fail_o), 1);
        chk("R10 act unchanged", 32'(act_o), 0);
        @(negedge clk); #5; chk("R10 pulse one cycle", 32'(load_fail_o), 0);
        @(negedge clk); do_exit(); #5; chk("R10 bits unchanged", saved_o, 32'hA);
        @(negedge clk);

        // random phase, compared each cycle against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            retire_i    = ($urandom_range(0, 2) == 0);
            sti_i       = ($urandom_range(0, 9) == 0);
            if_flag_i   = $urandom_range(0, 1);
            ss_load_i   = ($urandom_range(0, 12) == 0);
            nmi_dlv_i   = ($urandom_range(0, 15) == 0);
            smi_dlv_i   = ($urandom_range(0, 30) == 0);
            iret_i      = ($urandom_range(0, 8) == 0);
            smm_enter_i = ($urandom_range(0, 20) == 0);
            smm_exit_i  = ($urandom_range(0, 20) == 0);
            hlt_i       = ($urandom_range(0, 25) == 0);
            shutdown_i  = ($urandom_range(0, 80) == 0);
            sipi_i      = ($urandom_range(0, 5) == 0);
            vnmi_mode_i = ($urandom_range(0, 3) == 0);
            enclave_i   = $urandom_range(0, 1);
            exit_i      = ($urandom_range(0, 3) == 0);
            load_i      = (r < 8);
            load_act_i  = 2'($urandom_range(0, 3));
            if (r < 3)      load_word_i = 32'(1) << $urandom_range(5, 31);
            else if (r < 4) load_word_i = 32'hFFFF_FFE0 | 32'($urandom_range(0, 31));
            else            load_word_i = 32'($urandom_range(0, 31));
            @(negedge clk);
        end
        clear_strobes();
        @(negedge clk);
        #5;
        finish_run();
    end
endmodule